// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration frames from a three-wire serial link (serial clock, serial data and a latch strobe) and turns them into parallel settings for two synthesizer channels. Each channel has a reference divider value, a main divider made of a 6-bit swallow count and an 11-bit program count, a prescaler-ratio select, and a run flag. A channel whose run flag is clear reports power-down to the rest of the chip.

The three serial wires are treated as slow asynchronous inputs. They are synchronised into the system clock domain, and their rising edges are detected there. Each detected serial-clock edge shifts one bit into a 22-bit frame register. Each detected latch-strobe edge decodes the two lowest frame bits and copies the payload into one of four destination latches. Nothing downstream changes while a frame is being shifted in.

Top module: `s3w_loader`

## Requirements
- R1: After reset all divider, prescaler and run fields of both channels read zero, so both power-down outputs read 1.
- R2: Frame bits enter MSB first, one per rising serial-clock edge. Only the most recent 22 bits count; earlier bits fall off the top.
- R3: Code 00 in frame bits [1:0] loads channel 2's R latch. The R value comes from bits [15:2] and the run flag from bit 21. Bits 20..16 of an R frame have no effect.
- R4: Code 01 loads channel 2's divider latch. The A value comes from bits [7:2], the B value from bits [18:8], and the prescaler select from bit 19 (1 selects 64/65).
- R5: Code 10 loads channel 1's R latch, using the same field layout as R3.
- R6: Code 11 loads channel 1's divider latch, using the same field layout as R4.
- R7: Outputs never change while bits are being shifted. They change only on a rising edge of the latch strobe.
- R8: A channel's power-down output is the inverse of the run flag held in its R latch. Writing a run flag of 0 powers the channel down again.
- R9: A latch-strobe rising edge at the pins shows on the outputs after the third system-clock rising edge, and not before.
- R10: A write to one latch leaves the other three latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; a rising edge commits the frame |
| rf1_rcount | output | 14 | Channel 1 reference divider |
| rf1_acount | output | 6 | Channel 1 swallow count |
| rf1_bcount | output | 11 | Channel 1 program count |
| rf1_pre64 | output | 1 | Channel 1 prescaler select (1 = 64/65) |
| rf1_pdown | output | 1 | Channel 1 powered down |
| rf2_rcount | output | 14 | Channel 2 reference divider |
| rf2_acount | output | 6 | Channel 2 swallow count |
| rf2_bcount | output | 11 | Channel 2 program count |
| rf2_pre64 | output | 1 | Channel 2 prescaler select (1 = 64/65) |
| rf2_pdown | output | 1 | Channel 2 powered down |

## Verification
A pin change passes through two synchroniser flops and one update flop, so a committed frame appears after the third system-clock rising edge. The scoreboard monitor samples at the falling edge after the second rising edge, where it expects the previous settings, and again after the third, where it expects the new ones. Separately, the driver compares every output with the model just before each strobe, once all serial bits have been shifted and have settled.

// File: rtl/s3w_pkg.sv
package s3w_pkg;
  localparam int FRAME_W = 22;
  localparam int CTRL_W  = 2;
  localparam int R_W     = 14;
  localparam int A_W     = 6;
  localparam int B_W     = 11;
  localparam int N_CHAN  = 2;
  // field positions inside a frame
  localparam int R_LSB   = CTRL_W;
  localparam int A_LSB   = CTRL_W;
  localparam int B_LSB   = A_LSB + A_W;
  localparam int PRE_BIT = B_LSB + B_W;
  localparam int RUN_BIT = FRAME_W - 1;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    logic           pre;
    logic           run;
  } chan_cfg_t;
endpackage

// File: rtl/s3w_sync_edge.sv
module s3w_sync_edge #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_in[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl[i]  = chain_q[STAGES-1];
    assign rise[i] = chain_q[STAGES-1] & ~prev_q;
  end
endmodule

// File: rtl/s3w_shifter.sv
module s3w_shifter #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] frame_q
);
  logic [W-1:0] frame_d;

  always_comb begin
    frame_d = frame_q;
    if (shift_en) frame_d = {frame_q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_d;
  end
endmodule

// File: rtl/s3w_latch_bank.sv
module s3w_latch_bank
  import s3w_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [FRAME_W-1:0] frame,
  output chan_cfg_t          cfg [N_CHAN]
);
  logic [CTRL_W-1:0] code;
  assign code = frame[CTRL_W-1:0];

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
    localparam logic [CTRL_W-1:0] CODE_R  = CTRL_W'(2 * ch);
    localparam logic [CTRL_W-1:0] CODE_AB = CTRL_W'(2 * ch + 1);
    chan_cfg_t cfg_q, cfg_d;
    logic      load_r, load_ab;

    assign load_r  = commit && (code == CODE_R);
    assign load_ab = commit && (code == CODE_AB);

    always_comb begin
      cfg_d = cfg_q;
      if (load_r) begin
        cfg_d.r   = frame[R_LSB +: R_W];
        cfg_d.run = frame[RUN_BIT];
      end
      if (load_ab) begin
        cfg_d.a   = frame[A_LSB +: A_W];
        cfg_d.b   = frame[B_LSB +: B_W];
        cfg_d.pre = frame[PRE_BIT];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cfg_q <= '0;
      else if (load_r || load_ab)  cfg_q <= cfg_d;
    end

    assign cfg[ch] = cfg_q;
  end
endmodule

// File: rtl/s3w_loader.sv
module s3w_loader
  import s3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_le,
  output logic [R_W-1:0] rf1_rcount,
  output logic [A_W-1:0] rf1_acount,
  output logic [B_W-1:0] rf1_bcount,
  output logic           rf1_pre64,
  output logic           rf1_pdown,
  output logic [R_W-1:0] rf2_rcount,
  output logic [A_W-1:0] rf2_acount,
  output logic [B_W-1:0] rf2_bcount,
  output logic           rf2_pre64,
  output logic           rf2_pdown
);
  localparam int IDX_CLK  = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_LE   = 2;
  localparam int N_IN     = 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [N_IN-1:0]    in_lvl, in_rise;
  logic               sclk_rise, le_rise, sdata_lvl;
  logic [FRAME_W-1:0] frame_q;
  chan_cfg_t          cfg [N_CHAN];

  s3w_sync_edge #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in ({ser_le, ser_data, ser_clk}),
    .lvl      (in_lvl),
    .rise     (in_rise)
  );

  assign sclk_rise = in_rise[IDX_CLK];
  assign le_rise   = in_rise[IDX_LE];
  assign sdata_lvl = in_lvl[IDX_DATA];

  logic unused_sync;
  assign unused_sync = ^{in_lvl[IDX_CLK], in_lvl[IDX_LE], in_rise[IDX_DATA]};

  s3w_shifter #(.W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .shift_en (sclk_rise),
    .bit_in   (sdata_lvl),
    .frame_q  (frame_q)
  );

  s3w_latch_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .commit (le_rise),
    .frame  (frame_q),
    .cfg    (cfg)
  );

  // channel index 0 is RF2 (codes 00/01), index 1 is RF1 (codes 10/11)
  assign rf2_rcount = cfg[0].r;
  assign rf2_acount = cfg[0].a;
  assign rf2_bcount = cfg[0].b;
  assign rf2_pre64  = cfg[0].pre;
  assign rf2_pdown  = ~cfg[0].run;
  assign rf1_rcount = cfg[1].r;
  assign rf1_acount = cfg[1].a;
  assign rf1_bcount = cfg[1].b;
  assign rf1_pre64  = cfg[1].pre;
  assign rf1_pdown  = ~cfg[1].run;
endmodule

// File: rtl/s3w_loader_chk.sv
module s3w_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk_rise,
  input logic        le_rise,
  input logic        sdata_lvl,
  input logic [21:0] frame_q,
  input logic [13:0] rf1_rcount,
  input logic [5:0]  rf1_acount,
  input logic [10:0] rf1_bcount,
  input logic        rf1_pre64,
  input logic        rf1_pdown,
  input logic [13:0] rf2_rcount,
  input logic [5:0]  rf2_acount,
  input logic [10:0] rf2_bcount,
  input logic        rf2_pre64,
  input logic        rf2_pdown
);
  logic [32:0] rf1_all, rf2_all;
  assign rf1_all = {rf1_rcount, rf1_acount, rf1_bcount, rf1_pre64, rf1_pdown};
  assign rf2_all = {rf2_rcount, rf2_acount, rf2_bcount, rf2_pre64, rf2_pdown};

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> (frame_q[0] == $past(sdata_lvl)) && (frame_q[21:1] == $past(frame_q[20:0]))); // R2

  AST_HOLD_NO_LE: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(rf1_all) && $stable(rf2_all)); // R7

  AST_RF2_R_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && frame_q[1:0] == 2'b00) |=>
      (rf2_rcount == $past(frame_q[15:2])) && (rf2_pdown == !$past(frame_q[21]))); // R3

  AST_RF1_AB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && frame_q[1:0] == 2'b11) |=>
      (rf1_acount == $past(frame_q[7:2])) && (rf1_bcount == $past(frame_q[18:8]))
      && (rf1_pre64 == $past(frame_q[19]))); // R6

  AST_RF1_PD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && frame_q[1:0] == 2'b10) |=> (rf1_pdown == !$past(frame_q[21]))); // R8

  AST_ISOLATE_RF1: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !frame_q[1]) |=> $stable(rf1_all)); // R10
endmodule

bind s3w_loader s3w_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .sclk_rise  (sclk_rise),
  .le_rise    (le_rise),
  .sdata_lvl  (sdata_lvl),
  .frame_q    (frame_q),
  .rf1_rcount (rf1_rcount),
  .rf1_acount (rf1_acount),
  .rf1_bcount (rf1_bcount),
  .rf1_pre64  (rf1_pre64),
  .rf1_pdown  (rf1_pdown),
  .rf2_rcount (rf2_rcount),
  .rf2_acount (rf2_acount),
  .rf2_bcount (rf2_bcount),
  .rf2_pre64  (rf2_pre64),
  .rf2_pdown  (rf2_pdown)
);

// File: tb/s3w_loader_tb.sv
module s3w_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic ser_clk, ser_data, ser_le;
  logic [13:0] rf1_rcount, rf2_rcount;
  logic [5:0]  rf1_acount, rf2_acount;
  logic [10:0] rf1_bcount, rf2_bcount;
  logic        rf1_pre64, rf2_pre64, rf1_pdown, rf2_pdown;

  always #4 clk = ~clk;

  s3w_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .rf1_rcount(rf1_rcount), .rf1_acount(rf1_acount), .rf1_bcount(rf1_bcount),
    .rf1_pre64(rf1_pre64), .rf1_pdown(rf1_pdown),
    .rf2_rcount(rf2_rcount), .rf2_acount(rf2_acount), .rf2_bcount(rf2_bcount),
    .rf2_pre64(rf2_pre64), .rf2_pdown(rf2_pdown)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model, index 0 = RF2, index 1 = RF1
  logic [13:0] m_r   [2];
  logic [5:0]  m_a   [2];
  logic [10:0] m_b   [2];
  logic        m_pre [2];
  logic        m_run [2];

  logic [65:0] q_old [$];
  logic [65:0] q_new [$];
  string       q_tag [$];
  event        le_ev;

  function automatic logic [65:0] actual();
    return {rf1_rcount, rf1_acount, rf1_bcount, rf1_pre64, rf1_pdown,
            rf2_rcount, rf2_acount, rf2_bcount, rf2_pre64, rf2_pdown};
  endfunction

  function automatic logic [65:0] expected();
    return {m_r[1], m_a[1], m_b[1], m_pre[1], ~m_run[1],
            m_r[0], m_a[0], m_b[0], m_pre[0], ~m_run[0]};
  endfunction

  task automatic check(input string tag, input logic [65:0] exp_v);
    logic [65:0] act;
    act = actual();
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  function automatic void apply(input logic [21:0] f);
    int ch;
    ch = int'(f[1]);
    if (!f[0]) begin
      m_r[ch] = f[15:2]; m_run[ch] = f[21];
    end else begin
      m_a[ch] = f[7:2]; m_b[ch] = f[18:8]; m_pre[ch] = f[19];
    end
  endfunction

  function automatic logic [21:0] mk_r(input logic run, input logic [13:0] r, input logic [1:0] c);
    return {run, 5'b0, r, c};
  endfunction

  function automatic logic [21:0] mk_ab(input logic pre, input logic [10:0] b,
                                         input logic [5:0] a, input logic [1:0] c);
    return {2'b00, pre, b, a, c};
  endfunction

  task automatic shift_bit(input logic b);
    ser_data = b;
    ser_clk  = 1'b0;
    repeat (2) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  // driver: shift optional leading junk, then the frame, then strobe
  task automatic send(input logic [21:0] f, input int n_junk, input logic [7:0] junk,
                      input string tag);
    for (int i = n_junk - 1; i >= 0; i--) shift_bit(junk[i]);
    for (int i = 21; i >= 0; i--) shift_bit(f[i]);
    repeat (5) @(negedge clk);
    check({"R7 outputs moved before strobe ", tag}, expected());
    q_old.push_back(expected());
    apply(f);
    q_new.push_back(expected());
    q_tag.push_back(tag);
    ser_le = 1'b1;
    -> le_ev;
    repeat (8) @(negedge clk);
    ser_le = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: strobe set at a falling edge, update lands after the third rising edge
  initial begin
    forever begin
      @(le_ev);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check({"R9 early update ", q_tag[0]}, q_old.pop_front());
      @(posedge clk);
      @(negedge clk);
      check({q_tag.pop_front(), "/R10 committed value"}, q_new.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_r[c] = '0; m_a[c] = '0; m_b[c] = '0; m_pre[c] = 1'b0; m_run[c] = 1'b0;
    end
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_le = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 reset state", expected());
    send(mk_r(1'b1, 14'h1234, 2'b00), 0, 8'h00, "R3 rf2 R load, R8 run");
    send(mk_ab(1'b1, 11'h5A5, 6'h2A, 2'b01), 0, 8'h00, "R4 rf2 divider load");
    send(mk_r(1'b1, 14'h3FFF, 2'b10), 0, 8'h00, "R5 rf1 R load");
    send(mk_ab(1'b0, 11'h7FF, 6'h3F, 2'b11), 0, 8'h00, "R6 rf1 divider load");
    send(mk_r(1'b1, 14'h0001, 2'b10), 4, 8'h0B, "R2 leading junk dropped");
    send(mk_r(1'b0, 14'h2AAA, 2'b00), 0, 8'h00, "R8 rf2 powered down again");
    send(mk_r(1'b1, 14'h0155, 2'b00) | 22'h1F_0000, 0, 8'h00, "R3 unused bits ignored");
    send(mk_ab(1'b1, 11'h001, 6'h01, 2'b11), 0, 8'h00, "R6 rf1 divider reload");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule